// File: doc/BRIEF.md
# Flash Erase-Block Protection Unit

This unit keeps a protection state for every erase block of a multi-bank flash array and rules on each program or erase request before it reaches the array. Software changes a block's state with single-cycle commands carrying a block index. The unit then answers each operation start with a grant or a deny pulse. A protection-error flag stays set after a denial caused by a block's state, until a clear command resets it.

Each block is open, shut or pinned. Pinned means locked and also held by the hardware guard pin. While the guard pin is low, no command can take a pinned block out of that state. While the guard pin is high, a pinned block can be shut or opened like any other block. A digital two-bit voltage class, taken from outside, is looked at only when an operation is accepted. The block count is a parameter.

Top module: `flash_blk_guard`

## Requirements
- R1: While `rst_ni` is low, `grant_o`, `deny_o`, `busy_o` and `prot_err_o` are 0 and `stat_o` reads 2'b01. After a reset, every block reads 2'b01 (shut).
- R2: A command with `cmd_op_i` 2'b00 (open) or 2'b01 (shut) sets the indexed block to 2'b00 or 2'b01. No other block changes. The new value shows on `stat_o` in the cycle after the command's clock edge. `stat_o` is a combinational readback of the block chosen by `stat_blk_i`.
- R3: A command with `cmd_op_i` 2'b10 (pin) sets the indexed block to 2'b11 from any state, whatever the level of `hw_guard_i`.
- R4: While `hw_guard_i` is low, open and shut commands on a block in state 2'b11 are ignored, and the block stays 2'b11.
- R5: While `hw_guard_i` is high, open and shut commands on a block in state 2'b11 take it to 2'b00 or 2'b01.
- R6: An operation start on block state 2'b00, with `vcls_i` not 2'b00 and `busy_o` low, gives a one-cycle `grant_o` pulse in the cycle after the edge. `busy_o` rises in that same cycle and stays high until the edge at which `op_done_i` is seen.
- R7: An operation start while `vcls_i` is 2'b00 (lockout class) gives a one-cycle `deny_o` pulse and no grant, whatever the block's state. It does not set `prot_err_o`.
- R8: An operation start on a block whose state is not 2'b00, with the voltage class allowed, gives a `deny_o` pulse and sets `prot_err_o`. The flag stays set until a command with `cmd_op_i` 2'b11 (clear). If a clear and a new protection denial fall on the same edge, the flag stays set.
- R9: `vcls_i` is sampled only when an operation is accepted. Changing it while `busy_o` is high does not end the operation.
- R10: An operation start while `busy_o` is high is ignored and produces neither `grant_o` nor `deny_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low, synchronous |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 open, 01 shut, 10 pin, 11 clear error flag |
| cmd_blk_i | input | IW | Block index of the command |
| hw_guard_i | input | 1 | Low: pinned blocks are frozen |
| vcls_i | input | 2 | Program-voltage class, 00 = lockout |
| op_start_i | input | 1 | Program/erase start strobe |
| op_blk_i | input | IW | Block targeted by the operation |
| op_done_i | input | 1 | Operation finished |
| stat_blk_i | input | IW | Block index for the status readback |
| stat_o | output | 2 | State of the block chosen by `stat_blk_i` |
| grant_o | output | 1 | Operation granted (pulse) |
| deny_o | output | 1 | Operation refused (pulse) |
| busy_o | output | 1 | Granted operation in progress |
| prot_err_o | output | 1 | Sticky protection-error flag |

## Verification
State commands take effect one edge later. `stat_o` has no register of its own, so the new value is due in the cycle right after the command edge. Grant, deny, busy and the error flag are each one register away from a start, done or clear, so they are also due in the cycle after that edge. The reset gating acts at once. A behavioural model in the bench advances on each rising edge from the same inputs. The bench drives inputs a quarter period after the edge and compares every output against the model at the falling edge. Every result is therefore compared in exactly the cycle it is due.

// File: rtl/flash_blk_guard_pkg.sv
package flash_blk_guard_pkg;
   typedef enum logic [1:0] {
      BLK_OPEN   = 2'b00,
      BLK_SHUT   = 2'b01,
      BLK_PINNED = 2'b11
   } blk_state_e;

   typedef enum logic [1:0] {
      CMD_OPEN  = 2'b00,
      CMD_SHUT  = 2'b01,
      CMD_PIN   = 2'b10,
      CMD_CLEAR = 2'b11
   } blk_cmd_e;

   localparam logic [1:0] VCLS_LOCKOUT = 2'b00;
endpackage

// File: rtl/flash_blk_cell.sv
module flash_blk_cell
   import flash_blk_guard_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sel_i,
   input  logic       cmd_valid_i,
   input  logic [1:0] cmd_op_i,
   input  logic       hw_guard_i,
   output logic [1:0] st_o
);
   logic [1:0] st_q, st_d;
   logic       frozen;

   // a pinned block ignores open/shut while the guard pin is low
   assign frozen = (st_q == BLK_PINNED) && !hw_guard_i;

   always_comb begin
      st_d = st_q;
      if (sel_i && cmd_valid_i) begin
         unique case (cmd_op_i)
            CMD_OPEN:  if (!frozen) st_d = BLK_OPEN;
            CMD_SHUT:  if (!frozen) st_d = BLK_SHUT;
            CMD_PIN:   st_d = BLK_PINNED;
            default:   st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) st_q <= BLK_SHUT;
      else         st_q <= st_d;
   end

   assign st_o = st_q;

   // R1: reset leaves the block shut
   a_r1_reset_shut: assert property (@(posedge clk_i) !rst_ni |=> st_q == BLK_SHUT);
   // R3: pin command always lands
   a_r3_pin_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && cmd_valid_i && cmd_op_i == CMD_PIN) |=> st_q == BLK_PINNED);
   // R4: pinned block frozen while guard low
   a_r4_pin_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == BLK_PINNED && !hw_guard_i) |=> st_q == BLK_PINNED);
endmodule

// File: rtl/flash_blk_gate.sv
module flash_blk_gate
   import flash_blk_guard_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  logic       done_i,
   input  logic [1:0] vcls_i,
   input  logic [1:0] tgt_st_i,
   input  logic       clr_i,
   output logic       grant_o,
   output logic       deny_o,
   output logic       busy_o,
   output logic       err_o
);
   logic grant_q, deny_q, busy_q, err_q;
   logic attempt, volt_ok, blk_open, take, prot_miss;

   assign attempt   = start_i && !busy_q;
   assign volt_ok   = (vcls_i != VCLS_LOCKOUT);
   assign blk_open  = (tgt_st_i == BLK_OPEN);
   assign take      = attempt && volt_ok && blk_open;
   assign prot_miss = attempt && volt_ok && !blk_open;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         grant_q <= 1'b0;
         deny_q  <= 1'b0;
         busy_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         grant_q <= take;
         deny_q  <= attempt && !take;
         if (take)        busy_q <= 1'b1;
         else if (done_i) busy_q <= 1'b0;
         if (prot_miss)   err_q <= 1'b1;
         else if (clr_i)  err_q <= 1'b0;
      end
   end

   // outputs forced idle while reset is held
   assign grant_o = grant_q && rst_ni;
   assign deny_o  = deny_q  && rst_ni;
   assign busy_o  = busy_q  && rst_ni;
   assign err_o   = err_q   && rst_ni;

   // R7: lockout class refuses every start
   a_r7_lockout_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && vcls_i == VCLS_LOCKOUT) |=> (deny_o && !grant_o && !busy_o));
   // R8: closed block never granted
   a_r8_closed_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && tgt_st_i != BLK_OPEN) |=> (!grant_o && !busy_o));
   // R8: error flag sticky until clear
   a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && !clr_i) |=> err_o);
   // R9: busy not ended by anything but done
   a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !done_i) |=> busy_o);
   // R10: no verdict for a start while busy
   a_r10_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (!grant_o && !deny_o));
endmodule

// File: rtl/flash_blk_guard.sv
module flash_blk_guard
   import flash_blk_guard_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   localparam int IW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cmd_valid_i,
   input  logic [1:0]    cmd_op_i,
   input  logic [IW-1:0] cmd_blk_i,
   input  logic          hw_guard_i,
   input  logic [1:0]    vcls_i,
   input  logic          op_start_i,
   input  logic [IW-1:0] op_blk_i,
   input  logic          op_done_i,
   input  logic [IW-1:0] stat_blk_i,
   output logic [1:0]    stat_o,
   output logic          grant_o,
   output logic          deny_o,
   output logic          busy_o,
   output logic          prot_err_o
);
   localparam bit FULL_MAP = (NUM_BLOCKS == (1 << IW));

   if (NUM_BLOCKS < 2) begin : g_bad_count
      $error("flash_blk_guard: NUM_BLOCKS must be at least 2");
   end

   logic [1:0] blk_st [NUM_BLOCKS];
   logic [1:0] tgt_st, rd_st;

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
      flash_blk_cell u_cell (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .sel_i       (cmd_blk_i == IW'(b)),
         .cmd_valid_i (cmd_valid_i),
         .cmd_op_i    (cmd_op_i),
         .hw_guard_i  (hw_guard_i),
         .st_o        (blk_st[b])
      );
   end

   if (FULL_MAP) begin : g_direct
      assign tgt_st = blk_st[op_blk_i];
      assign rd_st  = blk_st[stat_blk_i];
   end else begin : g_ranged
      // indices past the last block read as shut and are never granted
      always_comb begin
         tgt_st = BLK_SHUT;
         rd_st  = BLK_SHUT;
         for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (op_blk_i == IW'(b))   tgt_st = blk_st[b];
            if (stat_blk_i == IW'(b)) rd_st  = blk_st[b];
         end
      end
   end

   assign stat_o = rst_ni ? rd_st : BLK_SHUT;

   flash_blk_gate u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (op_start_i),
      .done_i   (op_done_i),
      .vcls_i   (vcls_i),
      .tgt_st_i (tgt_st),
      .clr_i    (cmd_valid_i && cmd_op_i == CMD_CLEAR),
      .grant_o  (grant_o),
      .deny_o   (deny_o),
      .busy_o   (busy_o),
      .err_o    (prot_err_o)
   );

   // R6: a grant always comes with busy
   a_r6_grant_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o |-> busy_o);
   // R1: idle outputs while reset held
   a_r1_idle_in_reset: assert property (@(posedge clk_i)
      !rst_ni |-> (!grant_o && !deny_o && !busy_o && !prot_err_o && stat_o == BLK_SHUT));
endmodule

// File: tb/flash_blk_guard_tb.sv
module flash_blk_guard_tb_top;
   localparam int  NB = 16;
   localparam int  IW = 4;
   localparam time CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [IW-1:0] cmd_blk = '0;
   logic          guard = 1'b1;
   logic [1:0]    vcls = 2'b01;
   logic          op_start = 1'b0;
   logic [IW-1:0] op_blk = '0;
   logic          op_done = 1'b0;
   logic [IW-1:0] stat_blk = '0;
   logic [1:0]    stat;
   logic          grant, deny, busy, perr;

   int    n_tests = 0;
   int    n_fail  = 0;
   string phase   = "R1";

   flash_blk_guard #(.NUM_BLOCKS(NB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
      .cmd_blk_i(cmd_blk), .hw_guard_i(guard), .vcls_i(vcls), .op_start_i(op_start),
      .op_blk_i(op_blk), .op_done_i(op_done), .stat_blk_i(stat_blk), .stat_o(stat),
      .grant_o(grant), .deny_o(deny), .busy_o(busy), .prot_err_o(perr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_st[NB];
   bit m_busy, m_err, m_grant, m_deny, m_set;
   initial begin
      foreach (m_st[i]) m_st[i] = 1;
      {m_busy, m_err, m_grant, m_deny} = '0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_st[i]) m_st[i] = 1;
         {m_busy, m_err, m_grant, m_deny} = '0;
      end else begin
         m_grant = 0; m_deny = 0; m_set = 0;
         if (op_start && !m_busy) begin
            if (vcls == 2'b00) m_deny = 1;
            else if (m_st[op_blk] != 0) begin m_deny = 1; m_set = 1; m_err = 1; end
            else begin m_grant = 1; m_busy = 1; end
         end else if (m_busy && op_done) m_busy = 0;
         if (cmd_valid && cmd_op == 2'b11 && !m_set) m_err = 0;
         if (cmd_valid && cmd_op == 2'b10) m_st[cmd_blk] = 3;
         if (cmd_valid && cmd_op < 2'b10 && !(m_st[cmd_blk] == 3 && !guard))
            m_st[cmd_blk] = int'(cmd_op);
      end
   end

   task automatic chk(string tag, int got, int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // compare every cycle at the falling edge
   always @(negedge clk) begin
      chk({phase, " stat"},  int'(stat),  rst_n ? m_st[stat_blk] : 1);
      chk({phase, " grant"}, int'(grant), rst_n ? int'(m_grant) : 0);
      chk({phase, " deny"},  int'(deny),  rst_n ? int'(m_deny) : 0);
      chk({phase, " busy"},  int'(busy),  rst_n ? int'(m_busy) : 0);
      chk({phase, " perr"},  int'(perr),  rst_n ? int'(m_err) : 0);
   end

   task automatic nxt();
      @(posedge clk);
      #(CLK_PERIOD/4);
      cmd_valid = 1'b0;
      op_start  = 1'b0;
      op_done   = 1'b0;
   endtask

   task automatic cmd(logic [1:0] op, int blk);
      nxt();
      cmd_valid = 1'b1; cmd_op = op; cmd_blk = IW'(blk); stat_blk = IW'(blk);
      nxt();
   endtask

   task automatic start(int blk);
      nxt();
      op_start = 1'b1; op_blk = IW'(blk);
      nxt();
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog got 1 exp 0");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state, every block reads shut
      repeat (3) nxt();
      rst_n = 1'b1;
      for (int b = 0; b < NB; b++) begin nxt(); stat_blk = IW'(b); end
      @(negedge clk); chk("R1 direct", int'(stat), 1);

      phase = "R2";
      cmd(2'b00, 3);
      @(negedge clk); chk("R2 direct open", int'(stat), 0);
      cmd(2'b00, 5);
      cmd(2'b01, 3);
      @(negedge clk); chk("R2 direct shut", int'(stat), 1);
      nxt(); stat_blk = 4'd5;
      @(negedge clk); chk("R2 neighbour", int'(stat), 0);

      phase = "R6";
      nxt(); vcls = 2'b01; op_start = 1'b1; op_blk = 4'd5;
      @(negedge clk); chk("R6 no early grant", int'(grant), 0);
      nxt();
      @(negedge clk); chk("R6 grant", int'(grant), 1);
      phase = "R9";
      vcls = 2'b00;
      repeat (3) nxt();
      @(negedge clk); chk("R9 busy held", int'(busy), 1);
      phase = "R10";
      start(5);
      start(3);
      phase = "R6";
      nxt(); op_done = 1'b1;
      nxt();
      @(negedge clk); chk("R6 busy ends", int'(busy), 0);

      phase = "R7";
      vcls = 2'b00;
      start(5);
      start(3);
      @(negedge clk); chk("R7 no error", int'(perr), 0);

      phase = "R8";
      vcls = 2'b10;
      start(3);
      repeat (2) nxt();
      @(negedge clk); chk("R8 sticky", int'(perr), 1);
      cmd(2'b11, 0);
      @(negedge clk); chk("R8 cleared", int'(perr), 0);
      nxt(); op_start = 1'b1; op_blk = 4'd3; cmd_valid = 1'b1; cmd_op = 2'b11;
      nxt();
      @(negedge clk); chk("R8 set beats clear", int'(perr), 1);

      phase = "R3";
      guard = 1'b0;
      cmd(2'b10, 7);
      cmd(2'b10, 5);
      @(negedge clk); chk("R3 pinned", int'(stat), 3);
      phase = "R4";
      cmd(2'b00, 7);
      cmd(2'b01, 7);
      @(negedge clk); chk("R4 frozen", int'(stat), 3);
      start(7);

      phase = "R5";
      guard = 1'b1;
      cmd(2'b00, 7);
      @(negedge clk); chk("R5 open from pin", int'(stat), 0);
      cmd(2'b10, 7);
      cmd(2'b01, 7);
      @(negedge clk); chk("R5 shut from pin", int'(stat), 1);

      phase = "R1";
      vcls = 2'b01;
      cmd(2'b00, 9);
      start(9);
      nxt(); rst_n = 1'b0; stat_blk = 4'd9;
      @(negedge clk); chk("R1 busy in reset", int'(busy), 0);
      repeat (2) nxt();
      rst_n = 1'b1;
      nxt();
      @(negedge clk); chk("R1 shut after reset", int'(stat), 1);

      repeat (2) nxt();
      summary();
      $finish;
   end
endmodule